// File: doc/BRIEF.md
# Serial Amplifier Control and Status Link

This block runs, on the host side, a synchronous serial exchange with a remote power amplifier board. The host stores a small control word in local registers. The link then sends that word out, most significant bit first, over one data line. A shift clock paces the transfer, and a byte strobe pulses after each complete byte. During the same sixteen shift clocks the block reads a sixteen-bit status word from the return line. It keeps that word in two status registers, which the host reads back.

The control word carries one relay-enable bit for each amplifier channel, and every other bit goes out as zero. The status word that returns has two parts. The first byte is the remote board's echo of the first control byte from the previous exchange. The second byte carries a ready flag and a clip flag for each channel. An exchange begins when the host writes a go bit. It can also start on its own after a programmable idle gap, when automatic mode is on. A read of the command register shows whether a transfer is in progress.

Top module: `amp_link_host`

## Requirements
- R1: While reset is high, and in the cycle after it, every readable register returns zero, and the shift clock, the byte strobe and the data output are all low.
- R2: Address 0 keeps only wdata bits [N_CH-1:0] (relay enables) and reads back zero above them. Writes to address 1 are ignored and it always reads zero. In a frame, byte 0 carries those stored bits with zero above them, and byte 1 is all zeros.
- R3: A write to address 4 with bit 0 set starts a frame when no frame is running. The same write during a frame has no effect on that frame.
- R4: When address 4 bit 1 (automatic mode) is set, a new frame starts after AUTO_GAP consecutive idle cycles.
- R5: A frame lasts 33 half-periods of CLK_DIV system cycles each. The shift clock starts low, goes high in each even half-period from 0 to 30, and stays low whenever no frame is running.
- R6: The data output shows bit 15 of {byte0, byte1} from the start cycle, moves to the next lower bit only when the shift clock falls, and returns to zero after the last bit.
- R7: The return line is sampled on each rising shift clock, first bit first. At the end of a frame, address 2 gets the first 8 bits. Address 3 gets the last 8 bits, with ready flags in [2:0] and clip flags in [6:4]; bits 3 and 7 always read zero.
- R8: The byte strobe is high for exactly one half-period, right after the shift clock falls at the end of bit 8 and again at the end of bit 16.
- R9: Address 4 reads {6'b0, auto, busy}. Busy is high from the start edge until the end of the last half-period.
- R10: The status registers change only at the end of a frame. A read during a frame returns the values from the previous completed frame.
- R11: A write to address 0 during a frame does not change the bits of that frame. It takes effect in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Register address |
| host_we | input | 1 | Register write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| ser_clk | output | 1 | Serial shift clock |
| ser_latch | output | 1 | Byte strobe |
| ser_dout | output | 1 | Serial control data to the remote board |
| ser_din | input | 1 | Serial status data from the remote board |

## Verification
The assertions assume that the remote board changes ser_din only after a falling shift clock. They also assume that host writes arrive as one-cycle strobes on the system clock. The stimulus meets both assumptions because a behavioural model of the remote board drives ser_din. That model picks each bit from the half-period count, and the bench updates ser_din only on the falling system clock. That update happens at least CLK_DIV cycles before the next rising shift clock. Register accesses are issued one at a time through write and read tasks. They include go writes during a busy frame, on purpose.

// File: rtl/amp_link_pkg.sv
`timescale 1ns/1ps
package amp_link_pkg;
    localparam int BYTE_W     = 8;
    localparam int FRAME_BITS = 2 * BYTE_W;
    localparam int HALF_END   = 2 * FRAME_BITS;          // closing half-period index
    localparam int HALF_W     = $clog2(HALF_END + 1);
    localparam int ADDR_W     = 3;
    localparam int CMD_GO     = 0;
    localparam int CMD_AUTO   = 1;
    localparam int CLIP_LSB   = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL0 = 3'd0,
        A_CTRL1 = 3'd1,
        A_STAT0 = 3'd2,
        A_STAT1 = 3'd3,
        A_CMD   = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic sclk;
        logic latch;
        logic dout;
    } ser_pins_t;

    // bits of status byte 1 that carry per-channel flags
    function automatic logic [BYTE_W-1:0] flag_mask(input int n_ch);
        logic [BYTE_W-1:0] m;
        m = '0;
        for (int i = 0; i < n_ch; i++) begin
            m[i]            = 1'b1;
            m[CLIP_LSB + i] = 1'b1;
        end
        return m;
    endfunction

    // a byte strobe follows the falling edge that completes each byte
    function automatic logic byte_end(input logic [HALF_W-1:0] h);
        return (h == HALF_W'(2 * BYTE_W - 1)) || (h == HALF_W'(HALF_END - 1));
    endfunction
endpackage

// File: rtl/amp_link_seq.sv
`timescale 1ns/1ps
module amp_link_seq
    import amp_link_pkg::*;
#(
    parameter int CLK_DIV  = 4,
    parameter int AUTO_GAP = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic              auto_en,
    output logic              busy,
    output logic              go,
    output logic              tick,
    output logic              done,
    output logic [HALF_W-1:0] half
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int GAP_W = $clog2(AUTO_GAP + 1);

    logic [DIV_W-1:0] div_q;
    logic [GAP_W-1:0] idle_q;
    logic             auto_fire;

    assign tick      = busy && (div_q == DIV_W'(CLK_DIV - 1));
    assign done      = tick && (half == HALF_W'(HALF_END));
    assign auto_fire = auto_en && (idle_q == GAP_W'(AUTO_GAP - 1));
    assign go        = !busy && (start_req || auto_fire);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            div_q  <= '0;
            half   <= '0;
            idle_q <= '0;
        end else begin
            if (go) begin
                busy  <= 1'b1;
                div_q <= '0;
                half  <= '0;
            end else if (busy) begin
                if (tick) begin
                    div_q <= '0;
                    if (done) begin
                        busy <= 1'b0;
                        half <= '0;
                    end else begin
                        half <= half + 1'b1;
                    end
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
            if (busy || !auto_en || go) idle_q <= '0;
            else                        idle_q <= idle_q + 1'b1;
        end
    end
endmodule

// File: rtl/amp_link_shifter.sv
`timescale 1ns/1ps
module amp_link_shifter
    import amp_link_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  go,
    input  logic                  tick,
    input  logic [HALF_W-1:0]     half,
    input  logic [FRAME_BITS-1:0] tx_word,
    input  logic                  sdi,
    output ser_pins_t             pins,
    output logic [FRAME_BITS-1:0] rx_word
);
    logic [FRAME_BITS-1:0] tx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pins    <= '0;
            tx_q    <= '0;
            rx_word <= '0;
        end else if (go) begin
            tx_q       <= tx_word;
            pins.dout  <= tx_word[FRAME_BITS-1];
            pins.sclk  <= 1'b0;
            pins.latch <= 1'b0;
        end else if (tick) begin
            if (half == HALF_W'(HALF_END)) begin
                pins <= '0;
            end else if (!half[0]) begin
                pins.sclk  <= 1'b1;
                pins.latch <= 1'b0;
                rx_word    <= {rx_word[FRAME_BITS-2:0], sdi};
            end else begin
                pins.sclk  <= 1'b0;
                pins.latch <= byte_end(half);
                tx_q       <= tx_q << 1;
                pins.dout  <= (half == HALF_W'(HALF_END - 1)) ? 1'b0 : tx_q[FRAME_BITS-2];
            end
        end
    end
endmodule

// File: rtl/amp_link_regs.sv
`timescale 1ns/1ps
module amp_link_regs
    import amp_link_pkg::*;
#(
    parameter int N_CH = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [BYTE_W-1:0]     wdata,
    input  logic                  busy,
    input  logic                  commit,
    input  logic [FRAME_BITS-1:0] rx_word,
    output logic [FRAME_BITS-1:0] tx_word,
    output logic                  start_req,
    output logic                  auto_en,
    output logic [BYTE_W-1:0]     stat0,
    output logic [BYTE_W-1:0]     stat1,
    output logic [BYTE_W-1:0]     rdata
);
    localparam logic [BYTE_W-1:0] STAT1_MASK = flag_mask(N_CH);

    logic [N_CH-1:0] relay_q;
    logic            unused_wbits;

    assign unused_wbits = ^wdata;
    assign start_req    = we && (addr == A_CMD) && wdata[CMD_GO];
    assign tx_word      = {{(BYTE_W - N_CH){1'b0}}, relay_q, {BYTE_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            relay_q <= '0;
            auto_en <= 1'b0;
            stat0   <= '0;
            stat1   <= '0;
        end else begin
            if (we && addr == A_CTRL0) relay_q <= wdata[N_CH-1:0];
            if (we && addr == A_CMD)   auto_en <= wdata[CMD_AUTO];
            if (commit) begin
                stat0 <= rx_word[FRAME_BITS-1:BYTE_W];
                stat1 <= rx_word[BYTE_W-1:0] & STAT1_MASK;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL0: rdata = {{(BYTE_W - N_CH){1'b0}}, relay_q};
            A_STAT0: rdata = stat0;
            A_STAT1: rdata = stat1;
            A_CMD:   rdata = {{(BYTE_W - 2){1'b0}}, auto_en, busy};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/amp_link_host.sv
`timescale 1ns/1ps
module amp_link_host
    import amp_link_pkg::*;
#(
    parameter int CLK_DIV  = 4,
    parameter int AUTO_GAP = 1000,
    parameter int N_CH     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_we,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              ser_clk,
    output logic              ser_latch,
    output logic              ser_dout,
    input  logic              ser_din
);
    logic                  busy_w, go_w, tick_w, done_w, start_w, auto_w;
    logic [HALF_W-1:0]     half_w;
    logic [FRAME_BITS-1:0] tx_w, rx_w;
    logic [BYTE_W-1:0]     stat0_w, stat1_w;
    ser_pins_t             pins_w;

    amp_link_seq #(.CLK_DIV(CLK_DIV), .AUTO_GAP(AUTO_GAP)) u_seq (
        .clk(clk), .rst(rst), .start_req(start_w), .auto_en(auto_w),
        .busy(busy_w), .go(go_w), .tick(tick_w), .done(done_w), .half(half_w)
    );

    amp_link_shifter u_shift (
        .clk(clk), .rst(rst), .go(go_w), .tick(tick_w), .half(half_w),
        .tx_word(tx_w), .sdi(ser_din), .pins(pins_w), .rx_word(rx_w)
    );

    amp_link_regs #(.N_CH(N_CH)) u_regs (
        .clk(clk), .rst(rst), .we(host_we), .addr(host_addr), .wdata(host_wdata),
        .busy(busy_w), .commit(done_w), .rx_word(rx_w), .tx_word(tx_w),
        .start_req(start_w), .auto_en(auto_w), .stat0(stat0_w), .stat1(stat1_w),
        .rdata(host_rdata)
    );

    assign ser_clk   = pins_w.sclk;
    assign ser_latch = pins_w.latch;
    assign ser_dout  = pins_w.dout;
endmodule

// File: rtl/amp_link_chk.sv
`timescale 1ns/1ps
module amp_link_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       sclk,
    input logic       latch,
    input logic       sdo,
    input logic [7:0] stat0,
    input logic [7:0] stat1
);
    p_idle_lines_r5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!sclk && !latch && !sdo));

    p_latch_on_fall_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(latch) |-> $fell(sclk));

    p_latch_clock_low_r8: assert property (@(posedge clk) disable iff (rst)
        latch |-> !sclk);

    p_dout_steady_at_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> $stable(sdo));

    p_status_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        busy |-> ($stable(stat0) && $stable(stat1)));

    p_status_pad_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (!stat1[3] && !stat1[7]));
endmodule

bind amp_link_host amp_link_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy_w), .sclk(ser_clk), .latch(ser_latch),
    .sdo(ser_dout), .stat0(stat0_w), .stat1(stat1_w)
);

// File: tb/sim_amp_link_host.sv
`timescale 1ns/1ps
module sim_amp_link_host;
    localparam int DIV = 3;
    localparam int GAP = 20;
    localparam int FRAME_CYC = 33 * DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = '0;
    logic       we = 1'b0;
    logic [7:0] wdata = '0;
    logic       sdi = 1'b0;
    wire  [7:0] rdata;
    wire        sclk, latch, sdo;

    amp_link_host #(.CLK_DIV(DIV), .AUTO_GAP(GAP), .N_CH(3)) u0 (
        .clk(clk), .rst(rst), .host_addr(addr), .host_we(we), .host_wdata(wdata),
        .host_rdata(rdata), .ser_clk(sclk), .ser_latch(latch), .ser_dout(sdo),
        .ser_din(sdi)
    );

    always #10 clk = ~clk;   // 50 MHz

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done_flag = 0;

    // remote board flags for the next frame
    logic [2:0] rem_ready = '0, rem_clip = '0;
    logic       rem_pad = 1'b0;

    // behavioural reference
    bit         m_busy, m_auto;
    int         m_e, m_idle;
    logic [2:0] m_ctrl;
    logic [7:0] m_s0, m_s1, m_prev;
    logic [15:0] m_tx, m_rx;

    always @(posedge clk) begin : model
        bit go;
        if (rst) begin
            m_busy = 0; m_auto = 0; m_e = 0; m_idle = 0; m_ctrl = '0;
            m_s0 = '0; m_s1 = '0; m_prev = '0; m_tx = '0; m_rx = '0;
        end else begin
            go = !m_busy && ((we && addr == 3'd4 && wdata[0]) || (m_auto && m_idle == GAP - 1));
            if (m_busy || !m_auto || go) m_idle = 0; else m_idle++;
            if (m_busy) begin
                m_e++;
                if (m_e == FRAME_CYC) begin
                    m_busy = 0;
                    m_s0 = m_rx[15:8];
                    m_s1 = m_rx[7:0] & 8'h77;
                end
            end else if (go) begin
                m_busy = 1; m_e = 0;
                m_tx = {5'b0, m_ctrl, 8'h00};
                m_rx = {m_prev, rem_pad, rem_clip, rem_pad, rem_ready};
                m_prev = m_tx[15:8];
            end
            if (we && addr == 3'd0) m_ctrl = wdata[2:0];
            if (we && addr == 3'd4) m_auto = wdata[1];
        end
    end

    // remote board: presents bit j until the j-th falling shift clock
    always @(negedge clk) begin
        if (m_busy) begin
            int j;
            j = (m_e / DIV) / 2;
            if (j > 15) j = 15;
            sdi <= m_rx[15 - j];
        end else begin
            sdi <= 1'b0;
        end
    end

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return {5'b0, m_ctrl};
            3'd2: return m_s0;
            3'd3: return m_s1;
            3'd4: return {6'b0, m_auto, m_busy};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        #4;
        if (!rst && !done_flag) begin
            logic es, el, ed;
            es = 0; el = 0; ed = 0;
            if (m_busy) begin
                int nt, k;
                nt = m_e / DIV;
                if (nt == 0) ed = m_tx[15];
                else begin
                    k  = nt - 1;
                    es = (k % 2 == 0);
                    el = (k == 15 || k == 31);
                    if (k % 2 == 1) ed = (k == 31) ? 1'b0 : m_tx[15 - (k + 1) / 2];
                    else            ed = m_tx[15 - k / 2];
                end
            end
            check("R5", "ser_clk", {7'b0, sclk}, {7'b0, es});
            check("R8", "ser_latch", {7'b0, latch}, {7'b0, el});
            check("R6", "ser_dout", {7'b0, sdo}, {7'b0, ed});
            if (addr == 3'd2 || addr == 3'd3) check("R7", "rdata", rdata, exp_read(addr));
            else if (addr == 3'd4)            check("R9", "rdata", rdata, exp_read(addr));
            else                              check("R2", "rdata", rdata, exp_read(addr));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a;
        #6 d = rdata;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        check(req, "register read", d, exp);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_busy);
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done_flag) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected under 20000", cyc);
            finish_run();
        end
    end

    initial begin
        int lat_cnt;
        repeat (4) @(posedge clk);
        // R1: state during reset
        #2 check("R1", "ser pins in reset", {5'b0, sclk, latch, sdo}, 8'h00);
        @(negedge clk); rst = 1'b0;
        for (int a = 0; a < 5; a++) rd_chk("R1", 3'(a), 8'h00);

        // R2: only relay bits stored, address 1 ignored
        wr(3'd0, 8'hFD);
        rd_chk("R2", 3'd0, 8'h05);
        wr(3'd1, 8'hFF);
        rd_chk("R2", 3'd1, 8'h00);

        // frame 1: R3 start, R10 mid-frame hold, R11 mid-frame control write
        rem_ready = 3'b101; rem_clip = 3'b010; rem_pad = 1'b1;
        wr(3'd4, 8'h01);
        rd_chk("R9", 3'd4, 8'h01);
        rd_chk("R10", 3'd3, 8'h00);
        wr(3'd0, 8'h02);
        wr(3'd4, 8'h01);             // R3: ignored while busy
        repeat (30) @(negedge clk);
        rd_chk("R10", 3'd2, 8'h00);
        wait_idle();
        rd_chk("R9", 3'd4, 8'h00);
        rd_chk("R7", 3'd2, 8'h00);
        rd_chk("R7", 3'd3, 8'h25);

        // frame 2: echo of frame 1 control byte
        rem_ready = 3'b011; rem_clip = 3'b111;
        wr(3'd4, 8'h01);
        repeat (10) @(negedge clk);
        rd_chk("R10", 3'd3, 8'h25);
        wait_idle();
        rd_chk("R7", 3'd2, 8'h05);
        rd_chk("R7", 3'd3, 8'h73);

        // frame 3: shows the control written during frame 1 took effect in frame 2
        rem_pad = 1'b0; rem_ready = 3'b000; rem_clip = 3'b100;
        wr(3'd4, 8'h01);
        wait_idle();
        rd_chk("R11", 3'd2, 8'h02);
        rd_chk("R7", 3'd3, 8'h40);

        // R4: automatic mode, three frames inside the window
        addr = 3'd0;
        wr(3'd4, 8'h02);
        lat_cnt = 0;
        for (int i = 0; i < 360; i++) begin
            logic prev_l;
            prev_l = latch;
            @(negedge clk);
            if (latch && !prev_l) lat_cnt++;
        end
        check("R4", "strobes in auto window", 8'(lat_cnt), 8'd6);
        wr(3'd4, 8'h00);
        wait_idle();
        rd_chk("R4", 3'd4, 8'h00);

        // R1: reset in the middle of a frame
        wr(3'd4, 8'h01);
        repeat (40) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "ser pins after reset", {5'b0, sclk, latch, sdo}, 8'h00);
        rst = 1'b0;
        rd_chk("R1", 3'd0, 8'h00);
        rd_chk("R1", 3'd2, 8'h00);
        rd_chk("R1", 3'd4, 8'h00);
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule